// File: doc/BRIEF.md
# Daisy-chain echo SPI slave

This block is an SPI slave built for chained use. A single chip-select line frames every slave on the chain, and each slave's serial output feeds the next slave's serial input. The block keeps a shift register of `WORD_W` bits that persists across frames. On every sample edge it takes one bit from MOSI into the register's LSB. MISO always shows the register's MSB. The result is that each bit leaves the block exactly `WORD_W` sample edges after it entered. In the first `WORD_W` clocks of a frame the block sends out what it held before the frame. In the next `WORD_W` clocks it sends out an exact copy of what it just received. A chain of N slaves therefore behaves as one shift register of N·`WORD_W` bits.

SCLK, MOSI and chip select are oversampled by the system clock through two-flop synchronizers, and all edge detection is done in the system clock domain. The parameters `CPOL` and `CPHA` fix the bus mode: the idle clock level and whether data is sampled on the leading or the trailing edge. `DROP_LONG` decides what happens to the parallel output when a frame is longer than one word.

When chip select is released, the received word is offered on `rx_data` together with a one-cycle `rx_valid` strobe. This output is a valid-only stream with no ready. The consumer cannot apply back-pressure and must take the word in the cycle `rx_valid` is high. `rx_data` then holds that word until the next accepted frame. `miso_oe` is meant to drive an external tristate buffer on the shared MISO net.

Top module: `spi_echo_daisy`

## Requirements
- R1: After reset, `rx_data` is 0, `rx_valid` is 0, `miso_oe` is 0, and the shift register holds all zeros, so the first `WORD_W` bits sent on MISO are 0.
- R2: While `cs_n` is high, `miso_oe` stays 0 and `miso` does not change. Edges on `sclk` and changes on `mosi` leave the shift register unchanged, which shows in the bits MISO sends in the next frame.
- R3: While `cs_n` is held low, `miso_oe` is 1.
- R4: With `CPOL`=0 the clock idles low, and with `CPOL`=1 it idles high. With `CPHA`=0 MOSI is sampled on the first edge of each clock pulse, and with `CPHA`=1 on the second edge. Words travel MSB first.
- R5: The value on `miso` equals the MOSI bit captured `WORD_W` sample edges earlier, counting across frames. In a frame of 2·`WORD_W` bits, the second word out equals the first word in.
- R6: `miso` takes a new value when the block is selected and on every launch edge, which is the clock edge opposite the sample edge. It is stable at every sample edge.
- R7: A frame of exactly `WORD_W` sample edges ends with `rx_data` set to the received word and `rx_valid` high for exactly one system clock cycle.
- R8: A frame with fewer than `WORD_W` sample edges gives no `rx_valid` and leaves `rx_data` unchanged. Its bits are still shifted into the register.
- R9: With `DROP_LONG`=1, a frame longer than `WORD_W` gives no `rx_valid` and leaves `rx_data` unchanged, while shifting and echo continue for every bit.
- R10: With `DROP_LONG`=0, a frame longer than `WORD_W` is accepted. `rx_data` takes the last `WORD_W` bits received and `rx_valid` pulses once.
- R11: `rx_data` changes only in a cycle where `rx_valid` is 1, and `rx_valid` is only ever high while `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in (from master or previous slave) |
| cs_n | input | 1 | Shared active-low chip select |
| miso | output | 1 | Serial data out, register MSB |
| miso_oe | output | 1 | Drive enable for the external MISO tristate |
| rx_data | output | WORD_W | Word captured at the end of an accepted frame |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |

## Verification
The hardest case to reach is the over-long frame. Only in that frame do the echo and the parallel capture pull apart: the register keeps shifting while the parallel output must either stay frozen or take only the trailing word. The bench reaches it by having the master run 16-bit and 12-bit frames under one chip select. It first fills the register with a known word in an earlier exact frame. It then checks the whole MISO stream bit by bit against a model of the delay line, and checks that the second half of the stream repeats the first half of the input. A short frame placed between them moves the register by an odd number of bits, so the echo is also checked away from word alignment.

// File: rtl/spi_echo_pkg.sv
package spi_echo_pkg;
  // Per-cycle bus events seen in the system clock domain.
  typedef struct packed {
    logic sample;  // capture MOSI now
    logic launch;  // present the next MISO bit now
    logic sel;     // chip select just became active
    logic desel;   // chip select just went inactive
  } echo_evt_t;
endpackage

// File: rtl/spi_echo_sync.sv
module spi_echo_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_echo_edges.sv
module spi_echo_edges
  import spi_echo_pkg::*;
#(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s,
  input  logic      cs_n_s,
  output echo_evt_t evt,
  output logic      selected
);
  logic sclk_d, cs_n_d;
  logic rise, fall, lead, trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= CPOL;
      cs_n_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_n_d <= cs_n_s;
    end
  end

  assign selected = ~cs_n_s;

  always_comb begin
    rise  = sclk_s & ~sclk_d;
    fall  = ~sclk_s & sclk_d;
    lead  = CPOL ? fall : rise;
    trail = CPOL ? rise : fall;
    evt.sample = selected & (CPHA ? trail : lead);
    evt.launch = selected & (CPHA ? lead : trail);
    evt.sel    = cs_n_d & ~cs_n_s;
    evt.desel  = ~cs_n_d & cs_n_s;
  end
endmodule

// File: rtl/spi_echo_shifter.sv
module spi_echo_shifter
  import spi_echo_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter bit DROP_LONG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  echo_evt_t         evt,
  input  logic              mosi_s,
  output logic              miso,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              accept;

  // Persistent delay line: one bit in per sample edge, MSB is the echo.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shreg_q <= '0;
    else if (evt.sample) shreg_q <= {shreg_q[WORD_W-2:0], mosi_s};
  end

  // Bit count of the current frame, saturating one past a full word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (evt.sel)                        cnt_q <= '0;
    else if (evt.sample && cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     miso <= 1'b0;
    else if (evt.sel || evt.launch) miso <= shreg_q[WORD_W-1];
  end

  always_comb begin
    accept = (cnt_q == CNT_FULL) || (!DROP_LONG && cnt_q == CNT_OVER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= evt.desel & accept;
      if (evt.desel && accept) rx_data <= shreg_q;
    end
  end
endmodule

// File: rtl/spi_echo_daisy.sv
module spi_echo_daisy
  import spi_echo_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0,
  parameter bit DROP_LONG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              miso,
  output logic              miso_oe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam logic [2:0] SYNC_RST = {1'b1, 1'b0, CPOL};

  logic [2:0] bus_s;
  echo_evt_t  evt;
  logic       selected;

  spi_echo_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, mosi, sclk}),
    .q    (bus_s)
  );

  spi_echo_edges #(.CPOL(CPOL), .CPHA(CPHA)) u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (bus_s[0]),
    .cs_n_s  (bus_s[2]),
    .evt     (evt),
    .selected(selected)
  );

  spi_echo_shifter #(.WORD_W(WORD_W), .DROP_LONG(DROP_LONG)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .mosi_s  (bus_s[1]),
    .miso    (miso),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );

  assign miso_oe = selected;
endmodule

// File: rtl/spi_echo_daisy_chk.sv
module spi_echo_daisy_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              miso,
  input logic              miso_oe,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_valid
);
  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 1'b1;
  end

  p_quiet_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

  p_miso_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd1 && !miso_oe && $past(!miso_oe)) |-> $stable(miso));

  p_drive_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4 && !cs_n && $past(!cs_n) && $past(!cs_n, 2) && $past(!cs_n, 3)) |-> miso_oe);

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd1 && !rx_valid) |-> $stable(rx_data));

  p_strobe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !miso_oe);
endmodule

bind spi_echo_daisy spi_echo_daisy_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .miso    (miso),
  .miso_oe (miso_oe),
  .rx_data (rx_data),
  .rx_valid(rx_valid)
);

// File: tb/spi_echo_daisy_tb_top.sv
module spi_echo_daisy_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mosi = 1'b0;
  logic sclk_a = 1'b0, cs_a_n = 1'b1;
  logic sclk_b = 1'b1, cs_b_n = 1'b1;
  logic miso_a, oe_a, val_a, miso_b, oe_b, val_b;
  logic [W-1:0] data_a, data_b;
  logic [W-1:0] model_a = '0, model_b = '0;
  int checks = 0, errors = 0;
  int vcnt_a = 0, vcnt_b = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Mode 0, over-long frames dropped.
  spi_echo_daisy #(.WORD_W(W), .CPOL(1'b0), .CPHA(1'b0), .DROP_LONG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_a), .mosi(mosi), .cs_n(cs_a_n),
    .miso(miso_a), .miso_oe(oe_a), .rx_data(data_a), .rx_valid(val_a));

  // Mode 3, over-long frames accepted.
  spi_echo_daisy #(.WORD_W(W), .CPOL(1'b1), .CPHA(1'b1), .DROP_LONG(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_b), .mosi(mosi), .cs_n(cs_b_n),
    .miso(miso_b), .miso_oe(oe_b), .rx_data(data_b), .rx_valid(val_b));

  always @(posedge clk) begin
    if (val_a) vcnt_a <= vcnt_a + 1;
    if (val_b) vcnt_b <= vcnt_b + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Master frame on device 0 (mode 0) or 1 (mode 3); checks echo and drive enable.
  task automatic frame(input int dev, input int nbits, input logic [31:0] tx, input string req);
    logic [31:0] got, exp;
    logic oe_seen;
    logic b;
    got = '0; exp = '0; oe_seen = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      b = tx[nbits-1-i];
      if (dev == 0) begin exp[nbits-1-i] = model_a[W-1]; model_a = {model_a[W-2:0], b}; end
      else          begin exp[nbits-1-i] = model_b[W-1]; model_b = {model_b[W-2:0], b}; end
    end
    @(negedge clk);
    if (dev == 0) cs_a_n = 1'b0; else cs_b_n = 1'b0;
    idle(HALF);
    for (int i = 0; i < nbits; i++) begin
      b = tx[nbits-1-i];
      if (dev == 0) begin
        mosi = b; idle(HALF);
        got[nbits-1-i] = miso_a; oe_seen &= oe_a;
        sclk_a = 1'b1; idle(HALF);
        sclk_a = 1'b0;
      end else begin
        sclk_b = 1'b0; mosi = b; idle(HALF);
        got[nbits-1-i] = miso_b; oe_seen &= oe_b;
        sclk_b = 1'b1; idle(HALF);
      end
    end
    idle(HALF);
    if (dev == 0) cs_a_n = 1'b1; else cs_b_n = 1'b1;
    idle(10);
    check({req, " R5 echo stream"}, got, exp);
    check("R3 drive enable while selected", 32'(oe_seen), 32'd1);
  endtask

  task automatic t_reset;
    check("R1 oe after reset", 32'({oe_a, oe_b}), 32'd0);
    check("R1 valid after reset", 32'({val_a, val_b}), 32'd0);
    check("R1 data after reset", 32'({data_a, data_b}), 32'd0);
  endtask

  task automatic t_ignore_deselected;
    logic oe_any, miso_moved;
    logic m0;
    oe_any = 1'b0; miso_moved = 1'b0; m0 = miso_a;
    for (int i = 0; i < 10; i++) begin
      mosi = i[0]; sclk_a = 1'b1; idle(HALF);
      oe_any |= oe_a; miso_moved |= (miso_a !== m0);
      sclk_a = 1'b0; idle(HALF);
      oe_any |= oe_a; miso_moved |= (miso_a !== m0);
    end
    check("R2 no drive while deselected", 32'(oe_any), 32'd0);
    check("R2 miso frozen while deselected", 32'(miso_moved), 32'd0);
    check("R2 no strobe while deselected", 32'(vcnt_a), 32'd0);
    // Register must still be all zeros: R1/R2 shown by the first word out.
    frame(0, 8, 32'h00, "R2 R1 register untouched");
  endtask

  task automatic t_exact_mode0;
    int v0;
    v0 = vcnt_a;
    frame(0, 8, 32'hA5, "R4 R6 mode0 first word");
    check("R7 mode0 word A5", 32'(data_a), 32'hA5);
    frame(0, 8, 32'h3C, "R4 R6 mode0 echo of A5");
    check("R7 mode0 word 3C", 32'(data_a), 32'h3C);
    check("R7 one-cycle strobe per frame", 32'(vcnt_a - v0), 32'd2);
  endtask

  task automatic t_short_frame;
    int v0;
    v0 = vcnt_a;
    frame(0, 5, 32'h1B, "R8 short frame");
    check("R8 short frame keeps data", 32'(data_a), 32'h3C);
    check("R8 short frame no strobe", 32'(vcnt_a - v0), 32'd0);
  endtask

  task automatic t_long_drop;
    int v0;
    logic [15:0] tx;
    v0 = vcnt_a; tx = 16'hC396;
    frame(0, 16, 32'(tx), "R9 long frame");
    check("R9 long frame dropped, data kept", 32'(data_a), 32'h3C);
    check("R9 long frame no strobe", 32'(vcnt_a - v0), 32'd0);
    frame(0, 16, 32'h5AF0, "R5 chain double word");
    check("R5 second word out equals first word in", {24'd0, model_a}, 32'hF0);
  endtask

  task automatic t_mode3;
    int v0;
    v0 = vcnt_b;
    frame(1, 8, 32'h69, "R4 mode3 first word");
    check("R7 mode3 word 69", 32'(data_b), 32'h69);
    frame(1, 12, 32'hABC, "R4 R6 mode3 long frame");
    check("R10 long frame keeps last word", 32'(data_b), 32'hBC);
    check("R10 strobe count", 32'(vcnt_b - v0), 32'd2);
    frame(1, 8, 32'h00, "R5 mode3 echo of BC");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_ignore_deselected();
    t_exact_mode0();
    t_short_frame();
    t_long_drop();
    t_mode3();
    idle(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule